// File: doc/BRIEF.md
# Half-Precision Class Test Unit

This unit tests whether one 16-bit half-precision value belongs to any IEEE class in a set of classes chosen by the caller. It is used one vector lane at a time. Each request gives a value, a class-select mask and a lane index. On a clock edge with the valid strobe high, the unit sorts the value into exactly one of ten classes and ANDs that class with the mask. It then writes the single result bit into the destination lane mask at the given lane index.

A variant-select input makes the same result bit go into the execution lane mask too. When that input is low, the execution mask is left alone. Subnormal values keep their own class and are never treated as zero. Both masks hold their state between writes, and a synchronous reset clears them.

Top module: `fp16_class_unit`

## Requirements
- R1: A value with exponent field (bits 14:10) all ones, a non-zero mantissa (bits 9:0) and mantissa bit 9 equal to 0 is a signaling NaN, whatever its sign (bit 15). Mask bit 0 selects it.
- R2: A value with exponent all ones and mantissa bit 9 equal to 1 is a quiet NaN, whatever its sign. Mask bit 1 selects it.
- R3: A value with exponent all ones and a zero mantissa is an infinity. Mask bit 2 selects negative infinity and mask bit 9 selects positive infinity.
- R4: A value whose exponent is neither zero nor all ones is a normal number. Mask bit 3 selects negative normals and mask bit 8 selects positive normals.
- R5: A value with a zero exponent and a non-zero mantissa is a subnormal, with no flush to zero. Mask bit 4 selects negative subnormals and mask bit 7 selects positive subnormals. A value with a zero exponent and a zero mantissa is a zero: mask bit 5 selects negative zero and mask bit 6 selects positive zero.
- R6: The lane result is 1 exactly when the mask bit of the value's class is set. Mask bits 15:10 have no effect on the result.
- R7: On a rising clock edge with valid high, the destination-mask bit at the lane index takes the lane result, whether the result is 1 or 0. All other destination bits keep their values.
- R8: On a valid edge with the exec-update select high, the execution-mask bit at the lane index takes the same result. With the select low, the execution mask does not change.
- R9: On an edge with valid low, neither mask changes.
- R10: A synchronous active-low reset clears both masks to zero.
- R11: Every input value falls into exactly one of the ten classes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Write strobe for this cycle's request |
| update_exec_i | input | 1 | Also write the result into the execution mask |
| lane_i | input | 6 | Lane index to write |
| value_i | input | 16 | Half-precision operand |
| class_sel_i | input | 16 | Class-select mask; only bits 9:0 are used |
| dst_mask_o | output | 64 | Destination lane mask |
| exec_mask_o | output | 64 | Execution lane mask |

## Verification
The assertions assume that the lane index stays below the lane count. They also assume that valid, the exec-update select and the operands are stable and known at each rising edge. The stimulus drives all inputs only on falling edges and draws lane indices from 0 to 63. It walks every class with single-bit masks, all-class masks and masks with only the ignored upper bits set. It also inserts idle cycles with random operands and a reset in the middle of the run.

// File: rtl/fp16_class_pkg.sv
// Package: shared constants for the half-precision class test unit.
// Assumes binary16 layout: sign bit 15, exponent 14:10, mantissa 9:0.
package fp16_class_pkg;
    localparam int unsigned FP_W     = 16;
    localparam int unsigned EXP_W    = 5;
    localparam int unsigned MAN_W    = 10;
    localparam int unsigned NUM_CLS  = 10;

    // Class bit positions; the order is fixed because callers build masks from it.
    localparam int unsigned CLS_SNAN     = 0;
    localparam int unsigned CLS_QNAN     = 1;
    localparam int unsigned CLS_NEG_INF  = 2;
    localparam int unsigned CLS_NEG_NORM = 3;
    localparam int unsigned CLS_NEG_SUB  = 4;
    localparam int unsigned CLS_NEG_ZERO = 5;
    localparam int unsigned CLS_POS_ZERO = 6;
    localparam int unsigned CLS_POS_SUB  = 7;
    localparam int unsigned CLS_POS_NORM = 8;
    localparam int unsigned CLS_POS_INF  = 9;

    typedef logic [NUM_CLS-1:0] cls_vec_t;

    typedef enum logic [1:0] {
        EXP_ZERO = 2'd0,
        EXP_MID  = 2'd1,
        EXP_ONES = 2'd2
    } exp_kind_e;
endpackage

// File: rtl/fp16_classifier.sv
// Module: fp16_classifier
// Decodes one binary16 value into a one-hot ten-bit class vector.
// Assumes no denormal flushing; the sign of a NaN is ignored.
module fp16_classifier
    import fp16_class_pkg::*;
(
    input  logic [FP_W-1:0] value_i,
    output cls_vec_t        cls_o
);
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;
    exp_kind_e        ekind;
    logic             mant_nz;

    assign sign    = value_i[FP_W-1];
    assign expo    = value_i[FP_W-2:MAN_W];
    assign mant    = value_i[MAN_W-1:0];
    assign mant_nz = |mant;

    // Purpose: sort the exponent field into zero, all-ones or in-between.
    always_comb begin
        if (expo == '0)
            ekind = EXP_ZERO;
        else if (&expo)
            ekind = EXP_ONES;
        else
            ekind = EXP_MID;
    end

    // Purpose: raise exactly one class bit from exponent kind, mantissa and sign.
    always_comb begin
        cls_o = '0;
        unique case (ekind)
            EXP_ONES: begin
                if (!mant_nz)
                    cls_o[sign ? CLS_NEG_INF : CLS_POS_INF] = 1'b1;
                else if (mant[MAN_W-1])
                    cls_o[CLS_QNAN] = 1'b1;
                else
                    cls_o[CLS_SNAN] = 1'b1;
            end
            EXP_ZERO: begin
                if (mant_nz)
                    cls_o[sign ? CLS_NEG_SUB : CLS_POS_SUB] = 1'b1;
                else
                    cls_o[sign ? CLS_NEG_ZERO : CLS_POS_ZERO] = 1'b1;
            end
            default: begin
                cls_o[sign ? CLS_NEG_NORM : CLS_POS_NORM] = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/fp16_class_match.sv
// Module: fp16_class_match
// Reduces a one-hot class vector against the caller's select mask.
// Assumes SEL_W >= NUM_CLS; select bits above the class count are ignored.
module fp16_class_match
    import fp16_class_pkg::*;
#(
    parameter int unsigned SEL_W = 16
) (
    input  cls_vec_t         cls_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);
    localparam int unsigned HI_W = (SEL_W > NUM_CLS) ? SEL_W - NUM_CLS : 1;

    logic [HI_W-1:0] unused_sel_hi;

    // Purpose: keep the upper select bits visibly unused.
    generate
        if (SEL_W > NUM_CLS) begin : g_hi
            assign unused_sel_hi = sel_i[SEL_W-1:NUM_CLS];
        end else begin : g_nohi
            assign unused_sel_hi = '0;
        end
    endgenerate

    // Purpose: a hit exists when the active class is among the selected ones.
    always_comb begin
        hit_o = |(cls_i & sel_i[NUM_CLS-1:0]);
    end
endmodule

// File: rtl/lane_mask_reg.sv
// Module: lane_mask_reg
// Bank of per-lane flops; writes one indexed bit per enabled edge.
// Assumes an index at or above LANES never matches and so writes nothing.
module lane_mask_reg #(
    parameter int unsigned LANES  = 64,
    parameter int unsigned LANE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [LANE_W-1:0] idx_i,
    input  logic              d_i,
    output logic [LANES-1:0]  q_o
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Purpose: clear on reset, load only when this lane is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q_o[g] <= 1'b0;
                else if (we_i && (idx_i == LANE_W'(g)))
                    q_o[g] <= d_i;
            end
        end
    endgenerate

    // R10: a reset edge leaves the whole bank cleared.
    a_r10_reset_clears: assert property (@(posedge clk) !rst_n |=> q_o == '0);
endmodule

// File: rtl/fp16_class_unit.sv
// Module: fp16_class_unit
// Per-lane half-precision class test writing a destination mask and,
// when selected, the execution mask. Assumes lane_i < LANES on valid edges.
module fp16_class_unit
    import fp16_class_pkg::*;
#(
    parameter int unsigned LANES  = 64,
    parameter int unsigned SEL_W  = 16,
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              update_exec_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [FP_W-1:0]   value_i,
    input  logic [SEL_W-1:0]  class_sel_i,
    output logic [LANES-1:0]  dst_mask_o,
    output logic [LANES-1:0]  exec_mask_o
);
    cls_vec_t cls;
    logic     hit;
    logic     exec_we;

    fp16_classifier u_cls (
        .value_i (value_i),
        .cls_o   (cls)
    );

    fp16_class_match #(.SEL_W(SEL_W)) u_match (
        .cls_i (cls),
        .sel_i (class_sel_i),
        .hit_o (hit)
    );

    // Purpose: the exec bank is written only by the exec-updating variant.
    assign exec_we = valid_i && update_exec_i;

    lane_mask_reg #(.LANES(LANES), .LANE_W(LANE_W)) u_dst (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (valid_i),
        .idx_i (lane_i),
        .d_i   (hit),
        .q_o   (dst_mask_o)
    );

    lane_mask_reg #(.LANES(LANES), .LANE_W(LANE_W)) u_exec (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (exec_we),
        .idx_i (lane_i),
        .d_i   (hit),
        .q_o   (exec_mask_o)
    );

    // R11: the classifier always reports exactly one class.
    a_r11_one_class: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cls));

    // R7: the addressed destination bit carries the matcher's result.
    a_r7_dst_written: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> dst_mask_o[$past(lane_i)] == $past(hit));

    // R9: no strobe, no change to the destination mask.
    a_r9_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(dst_mask_o));

    // R8: exec bank untouched unless the exec-updating variant writes.
    a_r8_exec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && update_exec_i) |=> $stable(exec_mask_o));

    // R8: when both are written, the exec bit equals the destination bit.
    a_r8_exec_matches_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && update_exec_i) |=>
            exec_mask_o[$past(lane_i)] == dst_mask_o[$past(lane_i)]);
endmodule

// File: tb/fp16_class_unit_tb.sv
`timescale 1ns/1ps
// Bench: behavioural model of both lane masks, compared on every falling edge.
module fp16_class_unit_tb_top;
    localparam int LANES = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic        update_exec_i;
    logic [5:0]  lane_i;
    logic [15:0] value_i;
    logic [15:0] class_sel_i;
    logic [63:0] dst_mask_o;
    logic [63:0] exec_mask_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_dst = '0;
    logic [63:0] m_exec = '0;
    string last_tag = "R10";

    always #2 clk = ~clk;

    fp16_class_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .update_exec_i(update_exec_i),
        .lane_i(lane_i), .value_i(value_i), .class_sel_i(class_sel_i),
        .dst_mask_o(dst_mask_o), .exec_mask_o(exec_mask_o)
    );

    // Reference class index from the requirement text.
    function automatic int ref_class(input logic [15:0] v);
        int e = int'(v[14:10]);
        int m = int'(v[9:0]);
        bit neg = v[15];
        if (e == 31) begin
            if (m == 0) return neg ? 2 : 9;
            return (m >= 512) ? 1 : 0;
        end
        if (e == 0) begin
            if (m == 0) return neg ? 5 : 6;
            return neg ? 4 : 7;
        end
        return neg ? 3 : 8;
    endfunction

    task automatic check_masks();
        checks++;
        if (dst_mask_o !== m_dst) begin
            errors++;
            $display("FAIL %s dst actual %h expected %h", last_tag, dst_mask_o, m_dst);
        end
        checks++;
        if (exec_mask_o !== m_exec) begin
            errors++;
            $display("FAIL %s exec actual %h expected %h", last_tag, exec_mask_o, m_exec);
        end
    endtask

    // One cycle: compare previous result, then drive a new request.
    task automatic op(input logic [15:0] v, input logic [15:0] s, input int lane,
                      input bit upd, input bit vld, input bit rst, input string tag);
        bit res;
        @(negedge clk);
        check_masks();
        rst_n = ~rst;
        valid_i = vld;
        update_exec_i = upd;
        lane_i = 6'(lane);
        value_i = v;
        class_sel_i = s;
        res = s[ref_class(v)];
        if (rst) begin
            m_dst = '0;
            m_exec = '0;
        end else if (vld) begin
            m_dst[lane] = res;
            if (upd) m_exec[lane] = res;
        end
        last_tag = tag;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] vals [14];
        string tags [14];
        int k;
        vals = '{16'h7C01, 16'hFD00, 16'h7E00, 16'hFE01, 16'hFC00, 16'h7C00, 16'hC000,
                 16'h3C00, 16'h7BFF, 16'h0001, 16'h83FF, 16'h0000, 16'h8000, 16'h0400};
        tags = '{"R1", "R1", "R2", "R2", "R3", "R3", "R4",
                 "R4", "R4", "R5", "R5", "R5", "R5", "R4"};
        rst_n = 1'b0; valid_i = 1'b0; update_exec_i = 1'b0;
        lane_i = '0; value_i = '0; class_sel_i = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        last_tag = "R10";
        op(16'h0, 16'h0, 0, 1'b0, 1'b0, 1'b0, "R10");
        k = 0;
        // R1..R5, R11: each value against each single class bit
        for (int i = 0; i < 14; i++) begin
            for (int b = 0; b < 10; b++) begin
                op(vals[i], 16'(1 << b), (k * 7) % LANES, k[0], 1'b1, 1'b0, tags[i]);
                k++;
            end
            // R6: all classes selected, then only the ignored upper bits
            op(vals[i], 16'h03FF, i, 1'b1, 1'b1, 1'b0, "R6");
            op(vals[i], 16'hFC00, i, 1'b1, 1'b1, 1'b0, "R6");
        end
        // R7: set then clear the same lane, neighbours unaffected
        op(16'h3C00, 16'h0100, 40, 1'b0, 1'b1, 1'b0, "R7");
        op(16'h3C00, 16'h0200, 40, 1'b0, 1'b1, 1'b0, "R7");
        op(16'h3C00, 16'h0100, 63, 1'b0, 1'b1, 1'b0, "R7");
        // R8: exec only follows when the select is high
        op(16'h7C00, 16'h0200, 50, 1'b1, 1'b1, 1'b0, "R8");
        op(16'h7C00, 16'h0000, 50, 1'b0, 1'b1, 1'b0, "R8");
        op(16'h7C00, 16'h0000, 50, 1'b1, 1'b1, 1'b0, "R8");
        // R9: idle cycles with random operands
        for (int j = 0; j < 20; j++)
            op(16'($urandom), 16'($urandom), j * 3, j[0], 1'b0, 1'b0, "R9");
        // random mix
        for (int j = 0; j < 200; j++)
            op(16'($urandom), 16'($urandom), int'($urandom % LANES), 1'($urandom),
               1'($urandom), 1'b0, "R7");
        // R10: mid-run reset, then a write after it
        op(16'h0, 16'h0, 0, 1'b1, 1'b1, 1'b1, "R10");
        op(16'h0, 16'h0040, 5, 1'b1, 1'b1, 1'b0, "R10");
        op(16'h0, 16'h0, 0, 1'b0, 1'b0, 1'b0, "R9");
        @(negedge clk);
        check_masks();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule